// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire serial management bus (SMBus/I2C style) that gives a host access to a small file of byte-wide control registers. SCL and SDA are sampled by the system clock through a synchronizer. The block recognises start and stop conditions, matches its own address, and acknowledges bytes. It drives SDA only through an open-drain enable, pulling the line low. Every register byte appears in parallel on an output bus that feeds the clock-control logic.

A block write carries a starting index, then a byte count, then that many data bytes. The data bytes land in consecutive registers, and the index wraps from the last register back to zero. A block read first sets the index with a short write phase. The host then issues a repeated start and the read address. The target answers with the value of its byte-count register, followed by data bytes taken from consecutive registers, until the host refuses a byte. Two bytes of the file are fixed identification values that cannot be written. The last byte of the file is the byte count returned on reads, and the host can write it.

Top module: `smb_idx_regs`

## Requirements
- R1: The address byte 0xDC (write) and 0xDD (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged. The target then stays silent and writes nothing until the next start condition.
- R2: A write transfer carries, after 0xDC, a starting index N, then a count X, then X data bytes. Each of these bytes is acknowledged. The data bytes land in registers N, N+1, … in order.
- R3: Data bytes received after the X counted bytes are not acknowledged and leave every register unchanged. A count of 0 makes the first data byte unacknowledged.
- R4: The register index advances by one after every data byte, on both writes and reads. From index 8 it wraps to index 0.
- R5: A read transfer is 0xDC, index N, repeated start, then 0xDD. The target sends the value of register 8 first, then registers N, N+1, … (MSB first). It sends the next byte only when the host acknowledged the previous one. After a host non-acknowledge it releases SDA.
- R6: Register 8 is the read byte count. It resets to 0x09 and can be written like a control byte. A later read returns the written value as its first byte.
- R7: Registers 6 and 7 always read as the vendor identification (0x1A) and revision identification (0x03). Writes to them are acknowledged but have no effect.
- R8: After reset, registers 0 to 5 hold 0x00 and SDA is released.
- R9: The SDA pull-down enable changes only while SCL is low.
- R10: A starting index of 9 or more is taken as index 0.
- R11: A stop condition returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 72 | All nine register bytes, byte k on bits 8k+7..8k |

## Verification
The bench builds the block with its default values: nine registers, identification bytes at indices 6 and 7, and a two-stage synchronizer. At nine registers, writes can be swept exhaustively. Every starting index 0..8 and an out-of-range index are each combined with counts 0 to 3, so wrap-around at index 8, hits on the read-only bytes and writes to the count register all occur. Reads from every starting index check the returned count against the value the bench last wrote to register 8. A sweep over single-bit corruptions of the write address covers the non-acknowledge path.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

   // protocol engine states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_HACK
   } smbr_state_e;

   // meaning of the next received byte in a write transfer
   typedef enum logic [1:0] {
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } smbr_phase_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   initial begin : p_param_chk
      assert (STAGES >= 2 && STAGES <= 4)
         else $error("smbr_sync: STAGES out of range");
   end

   logic [1:0] raw;
   logic [1:0] synced;
   assign raw = {scl_i, sda_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain <= '1;
         else         chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign synced[l] = chain[STAGES-1];
   end

   logic scl_q, sda_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= synced[1];
         sda_q <= synced[0];
      end
   end

   assign scl_o      = synced[1];
   assign sda_o      = synced[0];
   assign scl_rise_o = synced[1] & ~scl_q;
   assign scl_fall_o = ~synced[1] & scl_q;
   assign start_o    = synced[1] & scl_q & sda_q & ~synced[0];
   assign stop_o     = synced[1] & scl_q & ~sda_q & synced[0];

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile #(
   parameter int unsigned NUM_REGS  = 9,
   parameter int unsigned CNT_IDX   = 8,
   parameter int unsigned VID_IDX   = 6,
   parameter int unsigned RID_IDX   = 7,
   parameter logic [7:0]  VENDOR_ID = 8'h1A,
   parameter logic [7:0]  REV_ID    = 8'h03,
   parameter logic [7:0]  RW_RESET  = 8'h00,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  we_i,
   input  logic [IDX_W-1:0]      waddr_i,
   input  logic [7:0]            wdata_i,
   input  logic [IDX_W-1:0]      raddr_i,
   output logic [7:0]            rdata_o,
   output logic [NUM_REGS*8-1:0] regs_o
);

   initial begin : p_param_chk
      assert (NUM_REGS >= 4 && NUM_REGS <= 256)
         else $error("smbr_regfile: NUM_REGS out of range");
      assert (VID_IDX != RID_IDX && VID_IDX != CNT_IDX && RID_IDX != CNT_IDX)
         else $error("smbr_regfile: special indices collide");
      assert (VID_IDX < NUM_REGS && RID_IDX < NUM_REGS && CNT_IDX < NUM_REGS)
         else $error("smbr_regfile: special index beyond file");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
      if (g == VID_IDX) begin : g_vid
         assign regs_o[g*8 +: 8] = VENDOR_ID;
      end else if (g == RID_IDX) begin : g_rid
         assign regs_o[g*8 +: 8] = REV_ID;
      end else begin : g_rw
         localparam logic [7:0] RST_VAL = (g == CNT_IDX) ? 8'(NUM_REGS) : RW_RESET;
         logic [7:0] q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                               q <= RST_VAL;
            else if (we_i && waddr_i == IDX_W'(g))     q <= wdata_i;
         end
         assign regs_o[g*8 +: 8] = q;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (raddr_i == IDX_W'(i)) rdata_o = regs_o[i*8 +: 8];
      end
   end

endmodule

// File: rtl/smbr_engine.sv
module smbr_engine
   import smbr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 9,
   parameter logic [6:0]  DEV_ADDR = 7'h6E,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam logic [7:0] WR_ADDR  = {DEV_ADDR, 1'b0},
   localparam logic [7:0] RD_ADDR  = {DEV_ADDR, 1'b1}
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [7:0]       cnt_i,
   input  logic [7:0]       rd_data_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             we_o,
   output logic [7:0]       wdata_o,
   output logic             sda_oe_o
);

   smbr_state_e      st;
   smbr_phase_e      ph;
   logic [7:0]       shr;
   logic [7:0]       txs;
   logic [3:0]       bcnt;
   logic [7:0]       rem;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_nxt;
   logic             to_tx;
   logic             hack;
   logic             oe;
   logic             byte_done;

   assign idx_nxt   = (idx == IDX_W'(NUM_REGS-1)) ? '0 : idx + 1'b1;
   assign byte_done = scl_fall_i && (bcnt == 4'd8);

   // a counted data byte is written in the cycle its ack decision is taken
   assign we_o    = (st == ST_RX) && byte_done && (ph == PH_DATA) && (rem != 8'd0)
                    && !start_i && !stop_i;
   assign wdata_o = shr;
   assign idx_o   = idx;
   assign sda_oe_o = oe;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st    <= ST_IDLE;
         ph    <= PH_INDEX;
         shr   <= '0;
         txs   <= '0;
         bcnt  <= '0;
         rem   <= '0;
         idx   <= '0;
         to_tx <= 1'b0;
         hack  <= 1'b0;
         oe    <= 1'b0;
      end else if (start_i) begin
         st   <= ST_ADDR;
         bcnt <= '0;
         oe   <= 1'b0;
      end else if (stop_i) begin
         st <= ST_IDLE;
         oe <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_RX: begin
               if (scl_rise_i) begin
                  shr  <= {shr[6:0], sda_i};
                  bcnt <= bcnt + 4'd1;
               end else if (byte_done) begin
                  bcnt <= '0;
                  if (st == ST_ADDR) begin
                     if (shr == WR_ADDR) begin
                        oe    <= 1'b1;
                        to_tx <= 1'b0;
                        ph    <= PH_INDEX;
                        st    <= ST_ACK;
                     end else if (shr == RD_ADDR) begin
                        oe    <= 1'b1;
                        to_tx <= 1'b1;
                        st    <= ST_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     to_tx <= 1'b0;
                     st    <= ST_ACK;
                     case (ph)
                        PH_INDEX: begin
                           idx <= (32'(shr) < NUM_REGS) ? shr[IDX_W-1:0] : '0;
                           oe  <= 1'b1;
                           ph  <= PH_COUNT;
                        end
                        PH_COUNT: begin
                           rem <= shr;
                           oe  <= 1'b1;
                           ph  <= PH_DATA;
                        end
                        default: begin
                           if (rem != 8'd0) begin
                              oe  <= 1'b1;
                              rem <= rem - 8'd1;
                              idx <= idx_nxt;
                           end else begin
                              oe <= 1'b0;
                           end
                        end
                     endcase
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall_i) begin
                  bcnt <= '0;
                  if (to_tx) begin
                     txs <= cnt_i;
                     oe  <= ~cnt_i[7];
                     st  <= ST_TX;
                  end else begin
                     oe <= 1'b0;
                     st <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall_i) begin
                  if (bcnt == 4'd7) begin
                     oe <= 1'b0;
                     st <= ST_HACK;
                  end else begin
                     txs  <= {txs[6:0], 1'b0};
                     oe   <= ~txs[6];
                     bcnt <= bcnt + 4'd1;
                  end
               end
            end
            ST_HACK: begin
               if (scl_rise_i) begin
                  hack <= ~sda_i;
               end else if (scl_fall_i) begin
                  if (hack) begin
                     txs  <= rd_data_i;
                     oe   <= ~rd_data_i[7];
                     bcnt <= '0;
                     idx  <= idx_nxt;
                     st   <= ST_TX;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_i) else $error("oe moved with SCL high"); // R9
   AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_IDLE) |-> !sda_oe_o) else $error("idle but driving"); // R11
   AST_IDX_IN_FILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(idx_o) < NUM_REGS) else $error("index beyond file"); // R4
   AST_WR_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_o |=> (rem == $past(rem) - 8'd1)) else $error("count not consumed"); // R3

endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs #(
   parameter int unsigned NUM_REGS    = 9,
   parameter int unsigned VID_IDX     = 6,
   parameter int unsigned RID_IDX     = 7,
   parameter logic [7:0]  VENDOR_ID   = 8'h1A,
   parameter logic [7:0]  REV_ID      = 8'h03,
   parameter logic [6:0]  DEV_ADDR    = 7'h6E,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CNT_IDX    = NUM_REGS - 1,
   localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] regs_o
);

   logic             scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
   logic             we;
   logic [7:0]       wdata, rdata;
   logic [IDX_W-1:0] idx;

   smbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_c),
      .stop_o     (stop_c)
   );

   smbr_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_s),
      .sda_i      (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_c),
      .stop_i     (stop_c),
      .cnt_i      (regs_o[CNT_IDX*8 +: 8]),
      .rd_data_i  (rdata),
      .idx_o      (idx),
      .we_o       (we),
      .wdata_o    (wdata),
      .sda_oe_o   (sda_oe_o)
   );

   smbr_regfile #(
      .NUM_REGS  (NUM_REGS),
      .CNT_IDX   (CNT_IDX),
      .VID_IDX   (VID_IDX),
      .RID_IDX   (RID_IDX),
      .VENDOR_ID (VENDOR_ID),
      .REV_ID    (REV_ID)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .waddr_i (idx),
      .wdata_i (wdata),
      .raddr_i (idx),
      .rdata_o (rdata),
      .regs_o  (regs_o)
   );

endmodule

// File: tb/smb_idx_regs_tb_top.sv
module smb_idx_regs_tb_top;

   localparam int Q = 6;
   localparam int NR = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_h = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [NR*8-1:0] regs;

   int n_chk = 0;
   int n_bad = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic [7:0] exp_r [NR];

   always #4 clk = ~clk;

   assign sda_line = sda_h & ~sda_oe;

   smb_idx_regs dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .regs_o   (regs)
   );

   // R9 monitor: enable may only move while SCL is low
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe !== oe_prev && scl) oe_viol++;
      oe_prev <= sda_oe;
   end

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic logic [NR*8-1:0] exp_vec();
      logic [NR*8-1:0] v;
      for (int i = 0; i < NR; i++) v[i*8 +: 8] = exp_r[i];
      return v;
   endfunction

   task automatic bus_start();
      sda_h = 1'b1; scl = 1'b1; hw(Q);
      sda_h = 1'b0; hw(Q);
      scl = 1'b0; hw(Q);
   endtask

   task automatic bus_rstart();
      sda_h = 1'b1; hw(Q);
      scl = 1'b1; hw(Q);
      sda_h = 1'b0; hw(Q);
      scl = 1'b0; hw(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; hw(Q);
      scl = 1'b1; hw(Q);
      sda_h = 1'b1; hw(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_h = b[i]; hw(Q);
         scl = 1'b1; hw(Q);
         scl = 1'b0; hw(Q);
      end
      sda_h = 1'b1; hw(Q);
      scl = 1'b1; hw(Q/2);
      ack = ~sda_line;
      hw(Q/2);
      scl = 1'b0; hw(Q);
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hw(Q);
         scl = 1'b1; hw(Q/2);
         b[i] = sda_line;
         hw(Q/2);
         scl = 1'b0;
      end
      hw(Q/2);
      sda_h = ~give_ack; hw(Q);
      scl = 1'b1; hw(Q);
      scl = 1'b0; hw(Q);
      sda_h = 1'b1;
   endtask

   task automatic blk_write(input int n, input int x, input bit extra);
      logic a;
      int base;
      logic [7:0] d;
      base = (n < NR) ? n : 0;
      bus_start();
      wr_byte(8'hDC, a); chk("R1 write address ack", a, 1);
      wr_byte(8'(n), a); chk("R2 index ack", a, 1);
      wr_byte(8'(x), a); chk("R2 count ack", a, 1);
      for (int k = 0; k < x; k++) begin
         int ix;
         d = 8'((n * 37 + x * 11 + k * 5 + 1) & 255);
         wr_byte(d, a); chk("R2 data ack", a, 1);
         ix = (base + k) % NR;  // R4 wrap, R10 out-of-range index
         if (ix != 6 && ix != 7) exp_r[ix] = d;  // R7 read-only bytes
      end
      if (extra) begin
         wr_byte(8'h5A, a); chk("R3 byte beyond count nacked", a, 0);
      end
      bus_stop();
      chk("R2 R4 R7 R10 register contents", 128'(regs), 128'(exp_vec()));
      chk("R11 released after stop", 128'(sda_oe), 0);
   endtask

   task automatic blk_read(input int n, input int len);
      logic a;
      logic [7:0] b;
      int base;
      base = (n < NR) ? n : 0;
      bus_start();
      wr_byte(8'hDC, a); chk("R5 write address ack", a, 1);
      wr_byte(8'(n), a); chk("R5 index ack", a, 1);
      bus_rstart();
      wr_byte(8'hDD, a); chk("R1 read address ack", a, 1);
      rd_byte(1'b1, b); chk("R5 R6 count byte", 128'(b), 128'(exp_r[NR-1]));
      for (int k = 0; k < len; k++) begin
         rd_byte(k != len - 1, b);
         chk("R4 R5 R7 read data", 128'(b), 128'(exp_r[(base + k) % NR]));
      end
      chk("R5 released after host nack", 128'(sda_oe), 0);
      bus_stop();
   endtask

   task automatic finish_run();
      chk("R9 enable moves only with SCL low", oe_viol, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin : main
      logic a;
      for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
      exp_r[6] = 8'h1A;
      exp_r[7] = 8'h03;
      exp_r[8] = 8'h09;
      hw(5);
      rst_n = 1'b1;
      hw(5);
      // R8 R6 R7 reset state
      chk("R8 R6 R7 reset contents", 128'(regs), 128'(exp_vec()));
      chk("R8 SDA released at reset", 128'(sda_oe), 0);

      // R1: single-bit corruptions of the write address are refused
      for (int bpos = 1; bpos < 8; bpos++) begin
         bus_start();
         wr_byte(8'hDC ^ 8'(1 << bpos), a); chk("R1 foreign address nacked", a, 0);
         wr_byte(8'h03, a); chk("R1 silent until next start", a, 0);
         bus_stop();
         chk("R1 foreign address writes nothing", 128'(regs), 128'(exp_vec()));
      end

      // R2 R3 R4 R7 R10: sweep starting index and count
      for (int n = 0; n <= NR; n++) begin
         for (int x = 0; x < 4; x++) begin
            blk_write((n == NR) ? 12 : n, x, 1'b1);
         end
      end

      // R6: set the count register explicitly, then read everywhere
      blk_write(8, 1, 1'b0);
      for (int n = 0; n <= NR; n++) blk_read((n == NR) ? 12 : n, 3);

      done = 1'b1;
      finish_run();
   end

endmodule